// File: doc/BRIEF.md
# Chained Transfer Sequencer

This block moves one data word on behalf of the CPU each time a peripheral interrupt activates it. For the source that fired, it first checks a global inhibit input. It then reads a vector word from a table in memory. That word gives the address of a five-word control record. The sequencer reads the record, copies one word from the record's source address to its destination address, and writes the updated count and addresses back into the record. If the record asks for chaining, the sequencer carries on with the record stored directly after it.

Each record has a transfer counter. When a move brings that counter from 1 to 0, control of the source goes back to the CPU. The sequencer clears the source's enable bit and pulses an interrupt that carries the source index. In repeat mode this happens only if the record asks for it. Otherwise the counter and any incrementing address are reloaded and the source keeps being served. One source index is treated as a timer. For that source, a flag bit in a status word is cleared before the move.

Record layout, as word offsets from the record address:
- offset 0: control byte. bit 0 is chain, bit 1 is repeat mode, bit 2 is interrupt-on-reload, bit 3 increments the source address, bit 4 increments the destination address.
- offset 1: counter.
- offset 2: reload value.
- offset 3: source address.
- offset 4: destination address.

Top module: `xfer_seq`

## Requirements
- R1: After an accepted activation, the sequencer reads `VEC_BASE + src`. It then reads record words 0 to 4 at the address returned by that read. Next it reads the source address and writes that word to the destination address. Finally it writes back the counter (offset 1), the source address (offset 3) and the destination address (offset 4).
- R2: When control bit 0 of a record is 1, the record at record address + 5 is processed next, with no vector read. The sequence ends after the first record whose bit 0 is 0.
- R3: With bit 1 = 0, the counter written back is the old counter minus 1. When the old counter was 1, the sequencer pulses `cpu_irq` for one cycle at the end of the sequence, with `irq_src` equal to the source index, and clears that source's enable bit.
- R4: With bit 1 = 1 and bit 2 = 0, an old counter of 1 writes back the reload value. Each incrementing address is written back as old address + 1 − reload. There is no interrupt and the enable bit stays set.
- R5: With bit 1 = 1 and bit 2 = 1, an old counter of 1 reloads the counter and addresses as in R4, and also raises the interrupt and clears the enable bit as in R3.
- R6: A source or destination address whose increment bit (bit 3 or bit 4) is 0 is written back unchanged. An address whose increment bit is 1 is written back plus 1, except on a reload.
- R7: For source index `TMR_SRC`, on the first record of the sequence, the sequencer reads `STAT_ADDR` and writes it back with bit `TMR_FLAG_BIT` cleared. Both accesses come before the data move.
- R8: An activation that starts while `inhibit` is 1 is discarded and no memory write takes place.
- R9: An activation whose source enable bit is 0 is ignored and no memory write takes place.
- R10: An activation that arrives while a sequence is running is held in one pending slot. It starts once the running sequence, including its chained records, has ended.
- R11: Enable bits form groups of 8. Source `s` uses group `s[5:3]`, bit `s[2:0]`. A write with `en_wr` replaces one group. Groups 4 and 7 do not exist: writes to them are dropped and their bits read as 0 (group 7 is not shown on `en_o`).
- R12: After reset all enable bits are 0, and `cpu_irq` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_req | input | 1 | Activation request strobe |
| act_src | input | 6 | Source index of the activation |
| inhibit | input | 1 | Global inhibit, tested when a sequence starts |
| en_wr | input | 1 | Write strobe for one enable group |
| en_grp | input | 3 | Enable group selected for writing |
| en_wdata | input | 8 | New value for the selected group |
| en_o | output | 56 | Enable bits, groups 0 to 6 |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| cpu_irq | output | 1 | One-cycle interrupt pulse to the CPU |
| irq_src | output | 6 | Source index that goes with `cpu_irq` |

## Verification
The hardest situation to bring about is the reload path in repeat mode. In that path the counter, the addresses, the interrupt and the enable bit all depend on one record crossing from 1 to 0. A second hard case is a chain whose exhaustion happens only on the second record. The stimulus reaches both by preloading record images with counter 1 and chosen reload values. It then fires one activation and reads the written-back words and `en_o`. The pending slot is reached by firing a second source a few cycles into the first sequence. The order of the two destination writes in the bus log is then compared.

// File: rtl/xfer_seq.sv
`timescale 1ns/1ps
module xfer_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int SW = 6,
  parameter int GB = 3,
  parameter int NGRP = 7,
  parameter int MISS_GRP = 4,
  parameter logic [AW-1:0] VEC_BASE = 16'h0040,
  parameter logic [SW-1:0] TMR_SRC = 6'd10,
  parameter logic [AW-1:0] STAT_ADDR = 16'h00F0,
  parameter int TMR_FLAG_BIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_req,
  input  logic [SW-1:0]    act_src,
  input  logic             inhibit,
  input  logic             en_wr,
  input  logic [GB-1:0]    en_grp,
  input  logic [7:0]       en_wdata,
  output logic [NGRP*8-1:0] en_o,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_we,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             cpu_irq,
  output logic [SW-1:0]    irq_src
);
  localparam int EN_W = NGRP * 8;
  localparam int EN_FULL = 1 << SW;
  localparam logic [AW-1:0] OFS_CNT = AW'(1);
  localparam logic [AW-1:0] OFS_RLD = AW'(2);
  localparam logic [AW-1:0] OFS_SRC = AW'(3);
  localparam logic [AW-1:0] OFS_DST = AW'(4);
  localparam logic [AW-1:0] REC_W = AW'(5);
  localparam logic [DW-1:0] ONE = DW'(1);
  localparam logic [DW-1:0] FLAG_MASK = ~(ONE << TMR_FLAG_BIT);

  typedef enum logic [3:0] {
    IDLE, VEC, RD_CTL, RD_CNT, RD_RLD, RD_SRC, RD_DST,
    ST_RD, ST_WR, MV_RD, MV_WR, WB_CNT, WB_SRC, WB_DST, FIN
  } st_t;

  st_t st, nst, pst;
  logic [SW-1:0] cur_src, psrc;
  logic          pend, first, irq_pend;
  logic [AW-1:0] rec;
  logic [7:0]    ctl;
  logic [DW-1:0] cnt, rld, sa, da;
  logic [EN_W-1:0] en;
  logic [EN_FULL-1:0] en_full;

  assign en_full = {{(EN_FULL-EN_W){1'b0}}, en};
  assign en_o = en;

  wire take = act_req && en_full[act_src];
  wire start = (st == IDLE) && (pend || take);
  wire [SW-1:0] start_src = pend ? psrc : act_src;
  wire clr = (st == FIN) && irq_pend;

  wire last = (cnt == ONE);
  wire rel  = ctl[1] && last;
  wire ex   = last && (!ctl[1] || ctl[2]);
  wire [DW-1:0] cnt_n = rel ? rld : cnt - ONE;
  wire [DW-1:0] sa_n  = !ctl[3] ? sa : (rel ? sa + ONE - rld : sa + ONE);
  wire [DW-1:0] da_n  = !ctl[4] ? da : (rel ? da + ONE - rld : da + ONE);

  assign cpu_irq = clr;
  assign irq_src = cur_src;

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : grp
      if (g == MISS_GRP) begin : absent
        assign en[g*8 +: 8] = 8'h00;
      end else begin : present
        logic [7:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r <= 8'h00;
          else begin
            if (en_wr && en_grp == GB'(g)) r <= en_wdata;
            if (clr && cur_src[SW-1:3] == GB'(g)) r[cur_src[2:0]] <= 1'b0;
          end
        end
        assign en[g*8 +: 8] = r;
      end
    end
  endgenerate

  always_comb begin
    nst = st;
    case (st)
      IDLE:   if (start && !inhibit) nst = VEC;
      VEC:    nst = RD_CTL;
      RD_CTL: nst = RD_CNT;
      RD_CNT: nst = RD_RLD;
      RD_RLD: nst = RD_SRC;
      RD_SRC: nst = RD_DST;
      RD_DST: nst = (first && cur_src == TMR_SRC) ? ST_RD : MV_RD;
      ST_RD:  nst = ST_WR;
      ST_WR:  nst = MV_RD;
      MV_RD:  nst = MV_WR;
      MV_WR:  nst = WB_CNT;
      WB_CNT: nst = WB_SRC;
      WB_SRC: nst = WB_DST;
      WB_DST: nst = ctl[0] ? RD_CTL : FIN;
      FIN:    nst = IDLE;
      default: nst = IDLE;
    endcase
  end

  always_comb begin
    mem_addr = '0;
    mem_we = 1'b0;
    mem_wdata = '0;
    case (st)
      VEC:    mem_addr = VEC_BASE + AW'(cur_src);
      RD_CTL: mem_addr = (pst == VEC) ? mem_rdata[AW-1:0] : rec;
      RD_CNT: mem_addr = rec + OFS_CNT;
      RD_RLD: mem_addr = rec + OFS_RLD;
      RD_SRC: mem_addr = rec + OFS_SRC;
      RD_DST: mem_addr = rec + OFS_DST;
      ST_RD:  mem_addr = STAT_ADDR;
      ST_WR:  begin mem_addr = STAT_ADDR; mem_we = 1'b1; mem_wdata = mem_rdata & FLAG_MASK; end
      MV_RD:  mem_addr = sa[AW-1:0];
      MV_WR:  begin mem_addr = da[AW-1:0]; mem_we = 1'b1; mem_wdata = mem_rdata; end
      WB_CNT: begin mem_addr = rec + OFS_CNT; mem_we = 1'b1; mem_wdata = cnt_n; end
      WB_SRC: begin mem_addr = rec + OFS_SRC; mem_we = 1'b1; mem_wdata = sa_n; end
      WB_DST: begin mem_addr = rec + OFS_DST; mem_we = 1'b1; mem_wdata = da_n; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; pst <= IDLE;
      cur_src <= '0; psrc <= '0; pend <= 1'b0;
      first <= 1'b0; irq_pend <= 1'b0;
      rec <= '0; ctl <= '0;
      cnt <= '0; rld <= '0; sa <= '0; da <= '0;
    end else begin
      st <= nst;
      pst <= st;
      if (start) begin
        pend <= pend && take;
        if (pend && take) psrc <= act_src;
        if (!inhibit) begin
          cur_src <= start_src;
          first <= 1'b1;
          irq_pend <= 1'b0;
        end
      end else if (take && !pend) begin
        pend <= 1'b1;
        psrc <= act_src;
      end
      case (pst)
        VEC:    rec <= mem_rdata[AW-1:0];
        RD_CTL: ctl <= mem_rdata[7:0];
        RD_CNT: cnt <= mem_rdata;
        RD_RLD: rld <= mem_rdata;
        RD_SRC: sa <= mem_rdata;
        RD_DST: da <= mem_rdata;
        default: ;
      endcase
      if (st == MV_RD) first <= 1'b0;
      if (st == WB_DST) begin
        if (ex) irq_pend <= 1'b1;
        if (ctl[0]) rec <= rec + REC_W;
      end
    end
  end

  // R1
  vector_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RD_CTL && pst == VEC) |-> mem_addr == mem_rdata[AW-1:0]);
  // R3
  irq_clears_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |=> !en_full[$past(irq_src)]);
  // R7
  timer_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR) |-> (mem_addr == STAT_ADDR && !mem_wdata[TMR_FLAG_BIT]));
  // R8
  inhibit_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && inhibit) |=> st == IDLE);
  // R10
  pending_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && pend && !inhibit) |=> st == VEC);
endmodule

// File: tb/tb_xfer_seq.sv
`timescale 1ns/1ps
module tb_xfer_seq;
  logic clk = 0, rst_n = 0;
  logic act_req = 0, inhibit = 0, en_wr = 0, mem_we, cpu_irq;
  logic [5:0] act_src = 0, irq_src;
  logic [2:0] en_grp = 0;
  logic [7:0] en_wdata = 0;
  logic [55:0] en_o;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  xfer_seq dut (.clk(clk), .rst_n(rst_n), .act_req(act_req), .act_src(act_src),
    .inhibit(inhibit), .en_wr(en_wr), .en_grp(en_grp), .en_wdata(en_wdata),
    .en_o(en_o), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .cpu_irq(cpu_irq), .irq_src(irq_src));

  logic [15:0] mem [256];
  logic tb_we = 0;
  logic [7:0] tb_a = 0;
  logic [15:0] tb_d = 0;
  logic [15:0] wlog [512];
  int wn = 0, irq_n = 0, last_irq_src = -1;
  int tests = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
    if (mem_we) begin wlog[wn % 512] <= mem_addr; wn <= wn + 1; end
    if (cpu_irq) begin irq_n <= irq_n + 1; last_irq_src <= int'(irq_src); end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); tb_we = 1; tb_a = a; tb_d = d;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic grp_wr(input logic [2:0] g, input logic [7:0] v);
    @(negedge clk); en_wr = 1; en_grp = g; en_wdata = v;
    @(negedge clk); en_wr = 0;
  endtask

  task automatic en_set(input logic [5:0] s);
    grp_wr(s[5:3], en_o[{s[5:3], 3'b000} +: 8] | (8'h01 << s[2:0]));
  endtask

  task automatic fire(input logic [5:0] s);
    @(negedge clk); act_req = 1; act_src = s;
    @(negedge clk); act_req = 0;
  endtask

  task automatic load_rec(input logic [7:0] ra, input logic [7:0] c, input logic [15:0] n,
                          input logic [15:0] r, input logic [15:0] s, input logic [15:0] d);
    poke(ra, {8'h00, c}); poke(ra + 8'd1, n); poke(ra + 8'd2, r);
    poke(ra + 8'd3, s); poke(ra + 8'd4, d);
  endtask

  // fields: src[93:88] ctl[87:80] cnt[79:64] rld[63:48] sa[47:32] da[31:16] data[15:0]
  localparam int NV = 6;
  localparam logic [93:0] TV [NV] = '{
    {6'd0,  8'h18, 16'd5, 16'd0, 16'h0010, 16'h0020, 16'h1234},
    {6'd9,  8'h18, 16'd1, 16'd0, 16'h0011, 16'h0021, 16'hBEEF},
    {6'd17, 8'h0A, 16'd1, 16'd4, 16'h0013, 16'h0024, 16'h5A5A},
    {6'd42, 8'h16, 16'd1, 16'd3, 16'h0015, 16'h002A, 16'hC3C3},
    {6'd48, 8'h00, 16'd7, 16'd0, 16'h0016, 16'h002C, 16'h0F0F},
    {6'd10, 8'h18, 16'd2, 16'd0, 16'h0017, 16'h002D, 16'h7777}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 en_o", en_o, 56'h0);
    chk("R12 cpu_irq", cpu_irq, 1'b0);
    chk("R12 mem_we", mem_we, 1'b0);
    rst_n = 1;
    @(negedge clk);

    // R11 group writes, group 4 absent
    grp_wr(3'd4, 8'hFF);
    chk("R11 group4 absent", en_o[39:32], 8'h00);
    grp_wr(3'd2, 8'hA5);
    chk("R11 group2 write", en_o[23:16], 8'hA5);
    grp_wr(3'd2, 8'h00);

    // table of single-record cases: R1 R3 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      logic [5:0] s; logic [7:0] c; logic [15:0] n, r, sa0, da0, dat;
      logic lst, rl, ex; logic [15:0] ecnt, esa, eda; int base, ib;
      {s, c, n, r, sa0, da0, dat} = TV[k];
      poke(8'h40 + {2'b00, s}, 16'h0080);
      load_rec(8'h80, c, n, r, sa0, da0);
      poke(sa0[7:0], dat); poke(da0[7:0], 16'h0);
      poke(8'hF0, 16'hFFFF);
      en_set(s);
      base = wn; ib = irq_n;
      fire(s);
      repeat (30) @(negedge clk);
      lst = (n == 16'd1); rl = c[1] && lst; ex = lst && (!c[1] || c[2]);
      ecnt = rl ? r : n - 16'd1;
      esa = !c[3] ? sa0 : (rl ? sa0 + 16'd1 - r : sa0 + 16'd1);
      eda = !c[4] ? da0 : (rl ? da0 + 16'd1 - r : da0 + 16'd1);
      chk("R1 moved word", mem[da0[7:0]], dat);
      chk("R3 R4 R5 counter writeback", mem[8'h81], ecnt);
      chk("R6 src writeback", mem[8'h83], esa);
      chk("R6 dst writeback", mem[8'h84], eda);
      chk("R3 R5 irq count", irq_n - ib, ex ? 1 : 0);
      chk("R3 R4 enable bit", en_o[s], !ex);
      if (ex) chk("R3 irq_src", last_irq_src, int'(s));
      if (s == 6'd10) begin
        chk("R7 status flag cleared", mem[8'hF0], 16'hFFF7);
        chk("R7 status write first", wlog[base % 512], 16'h00F0);
      end else begin
        chk("R1 move before writeback", wlog[base % 512], da0);
        chk("R7 status untouched", mem[8'hF0], 16'hFFFF);
      end
    end

    // R9 disabled source ignored
    begin
      int base;
      poke(8'h43, 16'h0080);
      load_rec(8'h80, 8'h18, 16'd4, 16'd0, 16'h0018, 16'h002E);
      poke(8'h18, 16'h4444); poke(8'h2E, 16'h0);
      base = wn;
      fire(6'd3);
      repeat (30) @(negedge clk);
      chk("R9 no writes", wn - base, 0);
      chk("R9 dst untouched", mem[8'h2E], 16'h0);
    end

    // R8 inhibit discards activation
    begin
      int base;
      en_set(6'd3);
      inhibit = 1;
      base = wn;
      fire(6'd3);
      repeat (30) @(negedge clk);
      chk("R8 no writes", wn - base, 0);
      chk("R8 counter kept", mem[8'h81], 16'd4);
      inhibit = 0;
    end

    // R2 chain, exhaustion on second record
    begin
      int ib;
      poke(8'h45, 16'h0090);
      load_rec(8'h90, 8'h19, 16'd3, 16'd0, 16'h0030, 16'h0034);
      load_rec(8'h95, 8'h00, 16'd1, 16'd0, 16'h0031, 16'h0035);
      poke(8'h30, 16'hAAAA); poke(8'h31, 16'hBBBB);
      poke(8'h34, 16'h0); poke(8'h35, 16'h0);
      en_set(6'd5);
      ib = irq_n;
      fire(6'd5);
      repeat (50) @(negedge clk);
      chk("R2 first move", mem[8'h34], 16'hAAAA);
      chk("R2 second move", mem[8'h35], 16'hBBBB);
      chk("R2 first counter", mem[8'h91], 16'd2);
      chk("R2 second counter", mem[8'h96], 16'd0);
      chk("R2 R3 irq", irq_n - ib, 1);
      chk("R2 R3 enable cleared", en_o[5], 1'b0);
    end

    // R10 pending activation
    begin
      int base, p1, p2;
      poke(8'h41, 16'h00A0); poke(8'h42, 16'h00A5);
      load_rec(8'hA0, 8'h18, 16'd4, 16'd0, 16'h0036, 16'h0038);
      load_rec(8'hA5, 8'h18, 16'd4, 16'd0, 16'h0037, 16'h0039);
      poke(8'h36, 16'h1111); poke(8'h37, 16'h2222);
      poke(8'h38, 16'h0); poke(8'h39, 16'h0);
      en_set(6'd1); en_set(6'd2);
      base = wn;
      fire(6'd1);
      @(negedge clk);
      fire(6'd2);
      repeat (60) @(negedge clk);
      chk("R10 first move", mem[8'h38], 16'h1111);
      chk("R10 pending move", mem[8'h39], 16'h2222);
      p1 = -1; p2 = -1;
      for (int i = base; i < wn; i++) begin
        if (wlog[i % 512] == 16'h0038 && p1 < 0) p1 = i;
        if (wlog[i % 512] == 16'h0039 && p2 < 0) p2 = i;
      end
      chk("R10 order", (p1 >= 0 && p2 > p1 + 3), 1'b1);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule